// File: doc/BRIEF.md
# Transfer Byte Counter with Shadow Address

This block keeps track of a data transfer that moves between host memory and a peripheral bus. Software loads a byte count and a host address through a small register port. Each time the bus side confirms that a byte has completed, the count steps down by one and a shadow address steps up by one. The shadow address therefore always names the next byte after the last one that actually completed. A separate host address counter has its own advance strobe. It can run ahead of the data, for example when the host side prefetches or writes ahead. The shadow address gives the true progress of the transfer.

Two sticky status bits record the events. The done bit is set when the count steps down to zero. The wrap bit is set when a completed byte arrives while the count is already zero. Software clears each bit by writing one to it in a clear register. A per-bit enable register selects which status bits drive the single interrupt output. A control register can zero the count at any time.

The register port is a plain strobe interface: a write takes effect at the clock edge where `reg_wr_en` is high. A read is requested with `reg_rd_en` and returns one cycle later with `reg_rd_valid`. The port cannot stall and never pushes back.

Top module: `xbc_top`

## Requirements
- R1: After reset, the count, host address, shadow address, status bits and enable bits are all zero, and `irq` is low.
- R2: A write to address 0 loads the count from `reg_wdata[23:0]`. A write to address 1 loads both the host address and the shadow address from `reg_wdata[31:0]`. A read returns the value at address 0 (count, zero-extended), 1 (host address) or 2 (shadow address) one cycle after `reg_rd_en`.
- R3: A `byte_ok` pulse with a nonzero count decrements the count by one and increments the shadow address by one. The shadow address rolls over from 0xFFFFFFFF to 0.
- R4: When a `byte_ok` pulse takes the count from 1 to 0, status bit 0 (done, read at address 3) is set.
- R5: A `byte_ok` pulse while the count is zero loads the count with 0xFFFFFF, sets status bit 1 (wrap), and increments the shadow address.
- R6: A `host_step` pulse increments only the host address. The shadow address and the count are unchanged.
- R7: Writing address 4 clears each status bit whose matching data bit is 1 (bit 0 done, bit 1 wrap) and leaves the others unchanged. If a clear and a set of the same bit happen in one cycle, the bit stays set.
- R8: Address 5 holds the interrupt enables (bit 0 done, bit 1 wrap). `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: Writing address 6 with bit 0 set zeroes the count and does not set the done bit.
- R10: A `byte_ok` pulse in the same cycle as a write to address 0, 1 or 6 is dropped. The write decides the count and the shadow address, and neither status bit is set by the pulse.
- R11: A `host_step` pulse in the same cycle as a write to address 1 is dropped, and the written value wins.
- R12: Writes to addresses 2 and 3 have no effect. Reads of addresses 4 and 6 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rd_data | output | 32 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read data valid, one cycle after reg_rd_en |
| byte_ok | input | 1 | One byte confirmed complete on the bus side |
| host_step | input | 1 | Advance the host address by one |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default widths: a 24-bit count, a 32-bit address and a 32-bit data port. Because the count and the addresses can be loaded directly, the count can be set to 0 or 1 and the address to 0xFFFFFFFF. That makes the wrap, done and address rollover edges reachable in a few cycles instead of 2^24 byte pulses. Same-cycle collisions of a register write with `byte_ok` or `host_step`, and of a clear with a set of the same status bit, are driven on purpose to exercise the priority rules.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  typedef enum logic [2:0] {
    REG_COUNT  = 3'd0,
    REG_HADDR  = 3'd1,
    REG_SHADOW = 3'd2,
    REG_STATUS = 3'd3,
    REG_CLEAR  = 3'd4,
    REG_IRQEN  = 3'd5,
    REG_CTRL   = 3'd6
  } xbc_reg_e;

  localparam int ST_DONE = 0;
  localparam int ST_WRAP = 1;
  localparam int NUM_ST  = 2;

endpackage

// File: rtl/xbc_count_unit.sv
module xbc_count_unit #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             zero_cmd,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             evt_done,
  output logic             evt_wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (zero_cmd) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign count    = cnt_q;
  assign evt_done = step && (cnt_q == ONE);
  assign evt_wrap = step && (cnt_q == '0);
endmodule

// File: rtl/xbc_addr_unit.sv
module xbc_addr_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              host_adv,
  input  logic              commit_adv,
  output logic [ADDR_W-1:0] host_addr,
  output logic [ADDR_W-1:0] shadow_addr
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(1);

  logic [ADDR_W-1:0] host_q;
  logic [ADDR_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q   <= '0;
      shadow_q <= '0;
    end else if (load) begin
      host_q   <= load_val;
      shadow_q <= load_val;
    end else begin
      if (host_adv)   host_q   <= host_q + INC;
      if (commit_adv) shadow_q <= shadow_q + INC;
    end
  end

  assign host_addr   = host_q;
  assign shadow_addr = shadow_q;
endmodule

// File: rtl/xbc_status_unit.sv
module xbc_status_unit #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_evt,
  input  logic [NBITS-1:0] clr_mask,
  input  logic             en_wr,
  input  logic [NBITS-1:0] en_val,
  output logic [NBITS-1:0] status,
  output logic [NBITS-1:0] enables,
  output logic             irq
);
  logic [NBITS-1:0] st_q;
  logic [NBITS-1:0] en_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
        en_q[i] <= 1'b0;
      end else begin
        if (set_evt[i])       st_q[i] <= 1'b1;
        else if (clr_mask[i]) st_q[i] <= 1'b0;
        if (en_wr)            en_q[i] <= en_val[i];
      end
    end
  end

  assign status  = st_q;
  assign enables = en_q;
  assign irq     = |(st_q & en_q);
endmodule

// File: rtl/xbc_top.sv
module xbc_top
  import xbc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_rd_valid,
  input  logic              byte_ok,
  input  logic              host_step,
  output logic              irq
);
  logic wr_count, wr_haddr, wr_clear, wr_irqen, wr_ctrl, blocking_wr;
  logic byte_take, host_take;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] host_q, shadow_q;
  logic [NUM_ST-1:0] st_q, en_q, set_evt, clr_mask;
  logic ev_done, ev_wrap;
  logic [DATA_W-1:0] rd_mux, rd_data_q;
  logic rd_valid_q;

  assign wr_count    = reg_wr_en && (reg_addr == REG_COUNT);
  assign wr_haddr    = reg_wr_en && (reg_addr == REG_HADDR);
  assign wr_clear    = reg_wr_en && (reg_addr == REG_CLEAR);
  assign wr_irqen    = reg_wr_en && (reg_addr == REG_IRQEN);
  assign wr_ctrl     = reg_wr_en && (reg_addr == REG_CTRL);
  assign blocking_wr = wr_count || wr_haddr || wr_ctrl;
  assign byte_take   = byte_ok && !blocking_wr;
  assign host_take   = host_step && !wr_haddr;

  xbc_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_count),
    .load_val (reg_wdata[CNT_W-1:0]),
    .zero_cmd (wr_ctrl && reg_wdata[0]),
    .step     (byte_take),
    .count    (cnt_q),
    .evt_done (ev_done),
    .evt_wrap (ev_wrap)
  );

  xbc_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (wr_haddr),
    .load_val    (reg_wdata[ADDR_W-1:0]),
    .host_adv    (host_take),
    .commit_adv  (byte_take),
    .host_addr   (host_q),
    .shadow_addr (shadow_q)
  );

  always_comb begin
    set_evt          = '0;
    set_evt[ST_DONE] = ev_done;
    set_evt[ST_WRAP] = ev_wrap;
    clr_mask         = wr_clear ? reg_wdata[NUM_ST-1:0] : '0;
  end

  xbc_status_unit #(.NBITS(NUM_ST)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .clr_mask (clr_mask),
    .en_wr    (wr_irqen),
    .en_val   (reg_wdata[NUM_ST-1:0]),
    .status   (st_q),
    .enables  (en_q),
    .irq      (irq)
  );

  always_comb begin
    unique case (reg_addr)
      REG_COUNT:  rd_mux = DATA_W'(cnt_q);
      REG_HADDR:  rd_mux = DATA_W'(host_q);
      REG_SHADOW: rd_mux = DATA_W'(shadow_q);
      REG_STATUS: rd_mux = DATA_W'(st_q);
      REG_IRQEN:  rd_mux = DATA_W'(en_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= reg_rd_en;
      if (reg_rd_en) rd_data_q <= rd_mux;
    end
  end

  assign reg_rd_data  = rd_data_q;
  assign reg_rd_valid = rd_valid_q;
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              byte_ok,
  input logic              host_step,
  input logic [CNT_W-1:0]  count,
  input logic [ADDR_W-1:0] host_addr,
  input logic [ADDR_W-1:0] shadow_addr,
  input logic [1:0]        status,
  input logic [1:0]        enables,
  input logic              irq
);
  logic blk, hwr, cwr;
  assign hwr = reg_wr_en && (reg_addr == 3'd1);
  assign cwr = reg_wr_en && (reg_addr == 3'd0);
  assign blk = reg_wr_en && (reg_addr == 3'd0 || reg_addr == 3'd1 || reg_addr == 3'd6);

  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !blk && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !blk && count == CNT_W'(1)) |=> status[0]);

  assert_wrap_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !blk && count == '0) |=> (status[1] && (&count)));

  assert_host_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_step && !hwr && !byte_ok) |=>
      (host_addr == $past(host_addr) + ADDR_W'(1) && $stable(shadow_addr)));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((status & enables) != 2'b00));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && cwr) |=> (count == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind xbc_top xbc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .byte_ok     (byte_ok),
  .host_step   (host_step),
  .count       (cnt_q),
  .host_addr   (host_q),
  .shadow_addr (shadow_q),
  .status      (st_q),
  .enables     (en_q),
  .irq         (irq)
);

// File: tb/xbc_top_tb_top.sv
module xbc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rd_data;
  logic        reg_rd_valid;
  logic        byte_ok = 1'b0;
  logic        host_step = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  xbc_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data),
    .reg_rd_valid(reg_rd_valid), .byte_ok(byte_ok), .host_step(host_step), .irq(irq)
  );

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (reg_rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL monitor: unexpected read data %h expected none", reg_rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rd_data !== e) begin
          failures++;
          $display("FAIL %s: read actual %h expected %h", t, reg_rd_data, e);
        end
      end
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // One cycle of stimulus, starting and ending at a falling edge.
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                     input logic bo, input logic hs);
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; byte_ok = bo; host_step = hs;
    @(negedge clk);
    reg_wr_en = 1'b0; byte_ok = 1'b0; host_step = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bit("R1 irq", irq, 1'b0);
    rd(3'd0, 32'h0, "R1 count");
    rd(3'd1, 32'h0, "R1 host");
    rd(3'd2, 32'h0, "R1 shadow");
    rd(3'd3, 32'h0, "R1 status");
    rd(3'd5, 32'h0, "R1 enables");
    // R2 loads
    wr(3'd0, 32'hAB00_0005);
    rd(3'd0, 32'h0000_0005, "R2 count");
    wr(3'd1, 32'h1000_0000);
    rd(3'd1, 32'h1000_0000, "R2 host");
    rd(3'd2, 32'h1000_0000, "R2 shadow");
    // R3 byte completion
    for (int i = 0; i < 3; i++) cyc(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    rd(3'd0, 32'h2, "R3 count");
    rd(3'd2, 32'h1000_0003, "R3 shadow");
    rd(3'd1, 32'h1000_0000, "R3 host untouched");
    // R6 host advance
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'd0, 32'h0, 1'b0, 1'b1);
    rd(3'd1, 32'h1000_0004, "R6 host");
    rd(3'd2, 32'h1000_0003, "R6 shadow");
    rd(3'd0, 32'h2, "R6 count");
    // R4 done
    cyc(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    rd(3'd3, 32'h0, "R4 not yet done");
    cyc(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    rd(3'd3, 32'h1, "R4 done");
    check_bit("R8 irq masked", irq, 1'b0);
    // R8 enable
    wr(3'd5, 32'h1);
    check_bit("R8 irq on done", irq, 1'b1);
    rd(3'd5, 32'h1, "R8 enables");
    // R7 clear
    wr(3'd4, 32'h2);
    rd(3'd3, 32'h1, "R7 other bit kept");
    wr(3'd4, 32'h1);
    rd(3'd3, 32'h0, "R7 cleared");
    check_bit("R8 irq after clear", irq, 1'b0);
    // R5 wrap
    cyc(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    rd(3'd0, 32'h00FF_FFFF, "R5 count");
    rd(3'd3, 32'h2, "R5 status");
    rd(3'd2, 32'h1000_0006, "R5 shadow");
    check_bit("R8 wrap not enabled", irq, 1'b0);
    wr(3'd5, 32'h3);
    check_bit("R8 irq on wrap", irq, 1'b1);
    // R7 set wins over clear
    wr(3'd0, 32'h0);
    cyc(1'b1, 3'd4, 32'h2, 1'b1, 1'b0);
    rd(3'd3, 32'h2, "R7 set wins");
    rd(3'd2, 32'h1000_0007, "R7 shadow");
    wr(3'd4, 32'h3);
    rd(3'd3, 32'h0, "R7 clear all");
    // R9 zero command
    rd(3'd0, 32'h00FF_FFFF, "R9 before");
    wr(3'd6, 32'h1);
    rd(3'd0, 32'h0, "R9 count zeroed");
    rd(3'd3, 32'h0, "R9 no done");
    // R10 write beats byte_ok
    cyc(1'b1, 3'd0, 32'h0000_000A, 1'b1, 1'b0);
    rd(3'd0, 32'hA, "R10 count write wins");
    rd(3'd2, 32'h1000_0007, "R10 shadow held");
    cyc(1'b1, 3'd6, 32'h1, 1'b1, 1'b0);
    rd(3'd0, 32'h0, "R10 ctrl wins");
    rd(3'd3, 32'h0, "R10 no wrap");
    rd(3'd2, 32'h1000_0007, "R10 shadow held 2");
    cyc(1'b1, 3'd1, 32'h0000_2000, 1'b1, 1'b0);
    rd(3'd2, 32'h0000_2000, "R10 shadow from write");
    rd(3'd0, 32'h0, "R10 count held");
    // R11 host write beats host_step
    cyc(1'b1, 3'd1, 32'h0000_3000, 1'b0, 1'b1);
    rd(3'd1, 32'h0000_3000, "R11 host");
    // R12 read-only and write-only addresses
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd3, 32'h3);
    rd(3'd2, 32'h0000_3000, "R12 shadow unchanged");
    rd(3'd3, 32'h0, "R12 status unchanged");
    rd(3'd4, 32'h0, "R12 clear reads zero");
    rd(3'd6, 32'h0, "R12 ctrl reads zero");
    // R3 shadow rollover
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'h2);
    cyc(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    rd(3'd2, 32'h0, "R3 shadow rollover");
    rd(3'd0, 32'h1, "R3 count after rollover");
    rd(3'd1, 32'hFFFF_FFFF, "R6 host held");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d reads outstanding expected 0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule